// File: doc/BRIEF.md
# Twelve-Hour BCD Timekeeping Counter

This block keeps the time of day on a twelve-hour face as six binary-coded decimal digits. A one-cycle enable, pulsed once per second by an upstream prescaler, advances the seconds. Seconds and minutes are each a modulus-60 stage: a units decade followed by a tens digit that runs from 0 to 5. Above them sits an hours stage that runs 1 through 12 and then returns to 1, never showing 0.

A stage moves only when the tick is high and every stage below it is at its last count. The whole chain therefore has a period of 60 × 60 × 12 = 43200 ticks. Every digit is a flip-flop output and all of them load on the same clock edge, so a display or decoder reading the digits never sees a half-updated time.

Top module: `hms_clock12`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets the time to 12:00:00, meaning hour tens 1, hour units 2 and all other digits 0. Reset wins over a tick at the same edge.
- R2: At an edge where secTick is low and rst is low, all six digits keep their values.
- R3: The seconds units digit goes up by one on each tick and goes from 9 back to 0. That wrap is the only event that carries into the seconds tens digit.
- R4: The seconds tens digit stays in 0..5. A tick at seconds 59 gives seconds 00 and advances the minutes units digit.
- R5: The minutes units digit (0..9) and minutes tens digit (0..5) follow the same scheme, but only on ticks where the seconds read 59. A tick at mm:59 = 59:59 gives 00:00 and advances the hours.
- R6: The hours read 01 to 12 (tens digit 0 or 1). A tick at 09:59:59 gives 10:00:00.
- R7: A tick at 12:59:59 gives 01:00:00.
- R8: Every digit is registered. All digits that change in response to a tick change together, at the first rising edge where that tick is sampled high.
- R9: 43200 consecutive ticks starting from any time bring the counter back to that same time.
- R10: Each digit is a 4-bit unsigned BCD value with bit 3 as the MSB. Values above 9 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset to 12:00:00, active high |
| secTick | input | 1 | One-cycle pulse that advances the time by one second |
| hourTens | output | 4 | Hours tens digit, BCD (0 or 1) |
| hourUnits | output | 4 | Hours units digit, BCD |
| minTens | output | 4 | Minutes tens digit, BCD (0..5) |
| minUnits | output | 4 | Minutes units digit, BCD |
| secTens | output | 4 | Seconds tens digit, BCD (0..5) |
| secUnits | output | 4 | Seconds units digit, BCD |

## Verification
The hardest conditions to reach are the hour boundaries. The 12-to-1 recycle needs 3600 ticks after reset, and the 09-to-10 step needs 36000. Random tick patterns almost never get there. The bench therefore drives an unbroken run of ticks straight from reset and checks the exact cycles 12:59:59→01:00:00 and 09:59:59→10:00:00, then continues until a full 43200-tick period closes. After that, sparse random ticks with occasional resets check the hold and carry behaviour against a reference model that counts elapsed seconds.

// File: rtl/hms_pkg.sv
package hms_pkg;
  localparam int DIGIT_W = 4;
  localparam int UNITS_LAST = 9;      // decade digit terminal count
  localparam int TENS_LAST = 5;       // modulus-6 digit terminal count
  localparam int HOUR_TOP_TENS = 1;   // 12 o'clock, tens
  localparam int HOUR_TOP_UNITS = 2;  // 12 o'clock, units
  localparam int HOUR_FIRST = 1;      // value after the top hour

  typedef logic [DIGIT_W-1:0] bcd_t;

  // advance strobes from control to datapath
  typedef struct packed {
    logic secUnits;
    logic secTens;
    logic minUnits;
    logic minTens;
    logic hours;
  } adv_t;
endpackage

// File: rtl/hms_bcd_digit.sv
module hms_bcd_digit
  import hms_pkg::*;
#(
  parameter int LAST = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output bcd_t value
);
  localparam bcd_t LAST_V = bcd_t'(LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (adv) begin
      if (value == LAST_V) value <= '0;
      else                 value <= value + bcd_t'(1);
    end
  end
endmodule

// File: rtl/hms_ctrl.sv
module hms_ctrl
  import hms_pkg::*;
(
  input  logic             secTick,
  input  bcd_t [3:0]       msDigits,  // 0 secU, 1 secT, 2 minU, 3 minT
  output adv_t             adv
);
  localparam bcd_t U_LAST = bcd_t'(UNITS_LAST);
  localparam bcd_t T_LAST = bcd_t'(TENS_LAST);

  logic [4:0] chain;

  always_comb begin
    chain[0] = secTick;
    chain[1] = chain[0] & (msDigits[0] == U_LAST);
    chain[2] = chain[1] & (msDigits[1] == T_LAST);
    chain[3] = chain[2] & (msDigits[2] == U_LAST);
    chain[4] = chain[3] & (msDigits[3] == T_LAST);
    adv.secUnits = chain[0];
    adv.secTens  = chain[1];
    adv.minUnits = chain[2];
    adv.minTens  = chain[3];
    adv.hours    = chain[4];
  end
endmodule

// File: rtl/hms_datapath.sv
module hms_datapath
  import hms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  adv_t       adv,
  output bcd_t [3:0] msDigits,
  output bcd_t       hourTens,
  output bcd_t       hourUnits
);
  localparam bcd_t TOP_T = bcd_t'(HOUR_TOP_TENS);
  localparam bcd_t TOP_U = bcd_t'(HOUR_TOP_UNITS);
  localparam bcd_t FIRST = bcd_t'(HOUR_FIRST);
  localparam bcd_t U_LAST = bcd_t'(UNITS_LAST);

  logic [3:0] advVec;
  assign advVec = {adv.minTens, adv.minUnits, adv.secTens, adv.secUnits};

  for (genvar i = 0; i < 4; i++) begin : g_ms
    localparam int LAST_I = (i % 2 == 0) ? UNITS_LAST : TENS_LAST;
    hms_bcd_digit #(.LAST(LAST_I)) u_digit (
      .clk  (clk),
      .rst  (rst),
      .adv  (advVec[i]),
      .value(msDigits[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hourTens  <= TOP_T;
      hourUnits <= TOP_U;
    end else if (adv.hours) begin
      if (hourTens == TOP_T && hourUnits == TOP_U) begin
        hourTens  <= '0;
        hourUnits <= FIRST;
      end else if (hourUnits == U_LAST) begin
        hourTens  <= hourTens + bcd_t'(1);
        hourUnits <= '0;
      end else begin
        hourUnits <= hourUnits + bcd_t'(1);
      end
    end
  end
endmodule

// File: rtl/hms_clock12.sv
module hms_clock12
  import hms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       secTick,
  output logic [3:0] hourTens,
  output logic [3:0] hourUnits,
  output logic [3:0] minTens,
  output logic [3:0] minUnits,
  output logic [3:0] secTens,
  output logic [3:0] secUnits
);
  adv_t       adv;
  bcd_t [3:0] msDigits;
  bcd_t       hT, hU;

  hms_ctrl u_ctrl (
    .secTick (secTick),
    .msDigits(msDigits),
    .adv     (adv)
  );

  hms_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .msDigits (msDigits),
    .hourTens (hT),
    .hourUnits(hU)
  );

  assign secUnits  = msDigits[0];
  assign secTens   = msDigits[1];
  assign minUnits  = msDigits[2];
  assign minTens   = msDigits[3];
  assign hourTens  = hT;
  assign hourUnits = hU;
endmodule

// File: rtl/hms_clock12_chk.sv
module hms_clock12_chk (
  input logic       clk,
  input logic       rst,
  input logic       secTick,
  input logic [3:0] hourTens,
  input logic [3:0] hourUnits,
  input logic [3:0] minTens,
  input logic [3:0] minUnits,
  input logic [3:0] secTens,
  input logic [3:0] secUnits
);
  a_r1_reset_time: assert property (@(posedge clk)
    rst |=> (hourTens == 4'd1 && hourUnits == 4'd2 && minTens == 4'd0 &&
             minUnits == 4'd0 && secTens == 4'd0 && secUnits == 4'd0));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !secTick |=> ($stable(secUnits) && $stable(secTens) && $stable(minUnits) &&
                  $stable(minTens) && $stable(hourUnits) && $stable(hourTens)));

  a_r3_units_wrap: assert property (@(posedge clk) disable iff (rst)
    (secTick && secUnits == 4'd9) |=> (secUnits == 4'd0));

  a_r4_sec_rollover: assert property (@(posedge clk) disable iff (rst)
    (secTick && secTens == 4'd5 && secUnits == 4'd9 && minUnits != 4'd9)
      |=> (secTens == 4'd0 && minUnits == $past(minUnits) + 4'd1));

  a_r5_min_hold_mid: assert property (@(posedge clk) disable iff (rst)
    (secTick && secUnits != 4'd9) |=> ($stable(minUnits) && $stable(minTens)));

  a_r6_hour_range: assert property (@(posedge clk) disable iff (rst)
    (hourTens == 4'd0) ? (hourUnits >= 4'd1 && hourUnits <= 4'd9)
                       : (hourTens == 4'd1 && hourUnits <= 4'd2));

  a_r7_twelve_to_one: assert property (@(posedge clk) disable iff (rst)
    (secTick && hourTens == 4'd1 && hourUnits == 4'd2 && minTens == 4'd5 &&
     minUnits == 4'd9 && secTens == 4'd5 && secUnits == 4'd9)
      |=> (hourTens == 4'd0 && hourUnits == 4'd1 && minTens == 4'd0 &&
           minUnits == 4'd0 && secTens == 4'd0 && secUnits == 4'd0));

  a_r10_bcd_range: assert property (@(posedge clk) disable iff (rst)
    (secUnits <= 4'd9 && minUnits <= 4'd9 && secTens <= 4'd5 && minTens <= 4'd5));
endmodule

bind hms_clock12 hms_clock12_chk u_chk (.*);

// File: tb/hms_clock12_test.sv
`timescale 1ns/1ps
module hms_clock12_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic secTick = 1'b0;
  logic [3:0] hourTens, hourUnits, minTens, minUnits, secTens, secUnits;

  int checks = 0;
  int errors = 0;
  int refSec = 0;   // seconds since 12:00:00, modulo 43200
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hms_clock12 uut (.*);

  function automatic int expHour(int s);
    int h = s / 3600;
    return (h == 0) ? 12 : h;
  endfunction

  function automatic logic [3:0] expDigit(int s, int idx);
    int m = (s / 60) % 60;
    int sec = s % 60;
    case (idx)
      0: return 4'(sec % 10);
      1: return 4'(sec / 10);
      2: return 4'(m % 10);
      3: return 4'(m / 10);
      4: return 4'(expHour(s) % 10);
      default: return 4'(expHour(s) / 10);
    endcase
  endfunction

  task automatic checkAll(string tag);
    logic [3:0] act [6];
    string dflt [6];
    act[0] = secUnits; act[1] = secTens; act[2] = minUnits;
    act[3] = minTens;  act[4] = hourUnits; act[5] = hourTens;
    dflt[0] = "R3"; dflt[1] = "R4"; dflt[2] = "R5";
    dflt[3] = "R5"; dflt[4] = "R6"; dflt[5] = "R6";
    for (int i = 0; i < 6; i++) begin
      logic [3:0] e = expDigit(refSec, i);
      checks++;
      if (act[i] !== e) begin
        errors++;
        $display("FAIL %s digit %0d actual %0d expected %0d (time ref %0d)",
                 (tag == "") ? dflt[i] : tag, i, act[i], e, refSec);
      end
    end
  endtask

  // drive at negedge, let one rising edge pass, check at next negedge
  task automatic step(bit tick, string tag);
    secTick = tick;
    @(posedge clk);
    if (tick) refSec = (refSec + 1) % 43200;
    @(negedge clk);
    secTick = 1'b0;
    checkAll((tag == "" && !tick) ? "R2" : tag);
  endtask

  task automatic doReset(bit tickToo);
    rst = 1'b1;
    secTick = tickToo;
    @(posedge clk);
    refSec = 0;
    @(negedge clk);
    checkAll("R1");
    rst = 1'b0;
    secTick = 1'b0;
  endtask

  task automatic runTicks(int n);
    secTick = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      refSec = (refSec + 1) % 43200;
    end
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'd1207));
    @(negedge clk);
    doReset(1'b0);          // R1
    step(1'b0, "R2");       // idle cycle holds
    step(1'b1, "R8");       // first tick shows after one edge
    doReset(1'b1);          // R1: reset beats tick

    // climb to 12:59:59, then the R7 recycle
    runTicks(3599);
    checkAll("R5");
    step(1'b1, "R7");
    // climb to 09:59:59, then 09 -> 10
    runTicks(35999 - 3600);
    checkAll("R6");
    step(1'b1, "R6");
    // complete one full period back to 12:00:00
    runTicks(43200 - 36000);
    checkAll("R9");
    step(1'b0, "R2");

    // sparse random ticks with occasional resets
    for (int k = 0; k < 6000; k++) begin
      int r = $urandom % 1000;
      if (r < 3) doReset(r[0]);
      else step((r % 3) != 0, "");
    end

    // full period from a non-zero starting time
    runTicks(43200);
    checkAll("R9");
    finishRun();
  end
endmodule